// File: doc/BRIEF.md
# Thermometer-Coded Sorting Accumulator with Tap Activation

This block computes one neuron of a ternary network without any adder or counter. Each of K input pairs carries a 2-bit thermometer activation and a 2-bit thermometer weight. A small gate network per pair turns them into a 2-bit thermometer product. All product bits, plus fixed padding bits, enter a bitonic sorting network built only from OR/AND compare-exchange cells. The sorted word is itself a thermometer word whose count of ones is the exact dot product, offset by half the word length.

An activation is then formed by tapping chosen positions of the sorted word. A small register table holds one position index per output bit, and each output bit is a straight copy of the sorted bit at that index. Monotonic index tables give piecewise-linear activations; a run of consecutive indices placed above the midpoint gives a shifted, clipped ReLU, which is how a folded batch-norm offset and slope are expressed. The datapath is purely combinational from the input codes to the outputs. Only the index table is clocked. It is written one entry at a time.

Top module: `tsa_top`

## Requirements
- R1: Ternary codes use bit 0 as the first stream position: 2'b00 is -1, 2'b01 is 0, 2'b11 is +1. Each pair's product is the ternary product of its activation and weight in the same code, so the sorted word gains exactly (product+1) ones per pair.
- R2: `sorted_out` is always a thermometer word: bit i+1 set implies bit i set, so its ones occupy positions 0 upward.
- R3: The number of ones in `sorted_out` equals the sum of all pair products plus N/2, where N is the smallest power of two not below 2*K (N=16 for K=6).
- R4: The N-2*K padding bits hold (N-2*K)/2 ones and the rest zeros; with every product at -1 the sorted word is exactly (N-2*K)/2 ones (16'h0003 for K=6).
- R5: Output bit j of `act_out` equals `sorted_out` at the position stored in table entry j, for any table contents, ordered or not.
- R6: After reset, table entry j holds N*j/OUT_LEN + N/(2*OUT_LEN) (2, 6, 10, 14 for the default sizes).
- R7: With `sel_we` high at a rising edge, entry `sel_addr` takes `sel_idx` and drives the outputs from then on; with `sel_we` low the table keeps its contents.
- R8: When the table entries are non-decreasing from entry 0 upward, `act_out` is a thermometer word.
- R9: Entries N/2+b+j for j=0..OUT_LEN-1 make the count of ones in `act_out` equal min(max(dot-b, 0), OUT_LEN), a clipped ReLU with threshold b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the index table |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_we | input | 1 | Write enable for one index table entry |
| sel_addr | input | AW (2) | Table entry to write |
| sel_idx | input | IDX_W (4) | Sorted position written into the entry |
| act_codes | input | 2*K (12) | Activation codes, pair i in bits 2i+1:2i |
| wgt_codes | input | 2*K (12) | Weight codes, pair i in bits 2i+1:2i |
| sorted_out | output | N (16) | Sorted thermometer accumulation |
| act_out | output | OUT_LEN (4) | Tapped thermometer activation |

## Verification
The bench builds the block with K=6 and OUT_LEN=4, which gives a 16-lane sorter with four padding bits, so the balanced padding and the exact zero offset are exercised along with all four merge stages. The four-entry table has a fully used address field, and 16 positions let the clipped-ReLU table be slid across the whole dot-product range from -6 to +6. Directed cases cover every multiplier code pair, the two extreme sums, reset contents and both ordered and unordered tables; random vectors then compare both outputs with an integer model.

// File: rtl/tsa_pkg.sv
package tsa_pkg;

  localparam logic [1:0] TCODE_NEG  = 2'b00;
  localparam logic [1:0] TCODE_ZERO = 2'b01;
  localparam logic [1:0] TCODE_POS  = 2'b11;

  // Smallest power of two that is at least n (and at least 2).
  function automatic int pow2_ceil(input int n);
    int p;
    p = 2;
    while (p < n) p = p * 2;
    return p;
  endfunction

  function automatic int tern_value(input logic [1:0] c);
    return int'(c[0]) + int'(c[1]) - 1;
  endfunction

endpackage

// File: rtl/tsa_tmul.sv
module tsa_tmul (
  input  logic [1:0] act,
  input  logic [1:0] wgt,
  output logic [1:0] prod
);
  import tsa_pkg::*;

  logic neg_hit;
  logic pos_hit;

  // -1 when the signs disagree, +1 when they agree and neither is zero
  assign neg_hit = (act[1] & ~wgt[0]) | (~act[0] & wgt[1]);
  assign pos_hit = (act[1] & wgt[1]) | (~act[0] & ~wgt[0]);

  assign prod[0] = ~neg_hit;
  assign prod[1] = pos_hit;

  always_comb begin
    if (!$isunknown({act, wgt}) && (act != 2'b10) && (wgt != 2'b10)) begin
      // R1
      tmul_value_chk: assert (tern_value(prod) == tern_value(act) * tern_value(wgt))
        else $error("product code does not match ternary product");
      // R1
      tmul_code_chk: assert (prod != 2'b10)
        else $error("product is not a thermometer code");
    end
  end

endmodule

// File: rtl/tsa_cmpx.sv
module tsa_cmpx (
  input  logic a,
  input  logic b,
  output logic hi,
  output logic lo
);
  assign hi = a | b;
  assign lo = a & b;
endmodule

// File: rtl/tsa_bitonic.sv
module tsa_bitonic #(
  parameter int N = 16
) (
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  localparam int LG     = $clog2(N);
  localparam int LAYERS = LG * (LG + 1) / 2;

  logic [N-1:0] net [0:LAYERS];

  assign net[0] = din;

  for (genvar gs = 0; gs < LG; gs++) begin : g_stage
    for (genvar gt = 0; gt <= gs; gt++) begin : g_step
      localparam int LYR  = gs * (gs + 1) / 2 + gt;
      localparam int BLK  = 2 << gs;
      localparam int DIST = 1 << (gs - gt);
      for (genvar gi = 0; gi < N; gi++) begin : g_lane
        localparam int PART = gi ^ DIST;
        if (PART > gi) begin : g_cell
          if ((gi & BLK) == 0) begin : g_down
            tsa_cmpx u_cx (
              .a (net[LYR][gi]),   .b (net[LYR][PART]),
              .hi(net[LYR+1][gi]), .lo(net[LYR+1][PART])
            );
          end else begin : g_up
            tsa_cmpx u_cx (
              .a (net[LYR][gi]),     .b (net[LYR][PART]),
              .hi(net[LYR+1][PART]), .lo(net[LYR+1][gi])
            );
          end
        end
      end
    end
  end

  assign dout = net[LAYERS];

  always_comb begin
    if (!$isunknown(din)) begin
      // R3
      sort_count_chk: assert ($countones(dout) == $countones(din))
        else $error("sorter changed the number of ones");
      // R2
      sort_therm_chk: assert (((dout >> 1) & ~dout) == '0)
        else $error("sorter output is not a thermometer word");
    end
  end

endmodule

// File: rtl/tsa_seltab.sv
module tsa_seltab #(
  parameter int N       = 16,
  parameter int OUT_LEN = 4,
  parameter int IDX_W   = 4,
  parameter int AW      = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [IDX_W-1:0]         wr_idx,
  output logic [OUT_LEN*IDX_W-1:0] tab_flat,
  output logic                     ordered
);
  localparam bit FULL_ADDR = (OUT_LEN == (1 << AW));

  logic [IDX_W-1:0] tab_q   [OUT_LEN];
  logic [IDX_W-1:0] tab_nxt [OUT_LEN];
  logic             addr_ok;

  assign addr_ok = FULL_ADDR || (int'(wr_addr) < OUT_LEN);

  always_comb begin
    for (int j = 0; j < OUT_LEN; j++) tab_nxt[j] = tab_q[j];
    if (wr_en && addr_ok) tab_nxt[wr_addr] = wr_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < OUT_LEN; j++)
        tab_q[j] <= IDX_W'((N * j) / OUT_LEN + N / (2 * OUT_LEN));
    end else if (wr_en) begin
      for (int j = 0; j < OUT_LEN; j++) tab_q[j] <= tab_nxt[j];
    end
  end

  for (genvar gj = 0; gj < OUT_LEN; gj++) begin : g_flat
    assign tab_flat[gj*IDX_W +: IDX_W] = tab_q[gj];
  end

  always_comb begin
    ordered = 1'b1;
    for (int j = 1; j < OUT_LEN; j++)
      if (tab_q[j] < tab_q[j-1]) ordered = 1'b0;
  end

  // R7
  tab_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr_ok) |=> (tab_q[$past(wr_addr)] == $past(wr_idx)))
    else $error("table write not taken");

  // R7
  tab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(tab_flat))
    else $error("table changed without a write");

endmodule

// File: rtl/tsa_top.sv
module tsa_top #(
  parameter int K       = 6,
  parameter int OUT_LEN = 4,
  localparam int RAW    = 2 * K,
  localparam int N      = tsa_pkg::pow2_ceil(RAW),
  localparam int PAD    = N - RAW,
  localparam int IDX_W  = $clog2(N),
  localparam int AW     = (OUT_LEN > 1) ? $clog2(OUT_LEN) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_we,
  input  logic [AW-1:0]      sel_addr,
  input  logic [IDX_W-1:0]   sel_idx,
  input  logic [2*K-1:0]     act_codes,
  input  logic [2*K-1:0]     wgt_codes,
  output logic [N-1:0]       sorted_out,
  output logic [OUT_LEN-1:0] act_out
);

  logic [1:0]               rst_pipe;
  logic                     rst_sync_n;
  logic [RAW-1:0]           prod_bits;
  logic [N-1:0]             sort_in;
  logic [OUT_LEN*IDX_W-1:0] tab_flat;
  logic                     tab_ordered;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  for (genvar gk = 0; gk < K; gk++) begin : g_mul
    tsa_tmul u_mul (
      .act (act_codes[2*gk +: 2]),
      .wgt (wgt_codes[2*gk +: 2]),
      .prod(prod_bits[2*gk +: 2])
    );
  end

  if (PAD > 0) begin : g_pad
    localparam logic [PAD-1:0] PAD_BITS = PAD'((1 << (PAD / 2)) - 1);
    assign sort_in = {PAD_BITS, prod_bits};
  end else begin : g_nopad
    assign sort_in = prod_bits;
  end

  tsa_bitonic #(.N(N)) u_sort (
    .din (sort_in),
    .dout(sorted_out)
  );

  tsa_seltab #(.N(N), .OUT_LEN(OUT_LEN), .IDX_W(IDX_W), .AW(AW)) u_tab (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (sel_we),
    .wr_addr (sel_addr),
    .wr_idx  (sel_idx),
    .tab_flat(tab_flat),
    .ordered (tab_ordered)
  );

  for (genvar gj = 0; gj < OUT_LEN; gj++) begin : g_tap
    assign act_out[gj] = sorted_out[tab_flat[gj*IDX_W +: IDX_W]];

    // R5
    tap_level_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      act_out[gj] == (int'(tab_flat[gj*IDX_W +: IDX_W]) < $countones(sorted_out)))
      else $error("tapped bit disagrees with accumulated count");
  end

  // R8
  act_therm_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tab_ordered |-> (((act_out >> 1) & ~act_out) == '0))
    else $error("ordered table gave a non-thermometer activation");

endmodule

// File: tb/tb_tsa_top.sv
`timescale 1ns/1ps
module tb_tsa_top;
  localparam int K = 6, OUT_LEN = 4, N = 16, IDX_W = 4, AW = 2;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               sel_we;
  logic [AW-1:0]      sel_addr;
  logic [IDX_W-1:0]   sel_idx;
  logic [2*K-1:0]     act_codes;
  logic [2*K-1:0]     wgt_codes;
  logic [N-1:0]       sorted_out;
  logic [OUT_LEN-1:0] act_out;

  int n_chk = 0;
  int n_err = 0;
  int av [K];
  int wv [K];
  int mtab [OUT_LEN];

  tsa_top #(.K(K), .OUT_LEN(OUT_LEN)) dut (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_addr(sel_addr),
    .sel_idx(sel_idx), .act_codes(act_codes), .wgt_codes(wgt_codes),
    .sorted_out(sorted_out), .act_out(act_out)
  );

  always #2.5 clk = ~clk;

  function automatic logic [1:0] enc(input int v);
    if (v < 0) return 2'b00;
    if (v == 0) return 2'b01;
    return 2'b11;
  endfunction

  function automatic int dot();
    int s = 0;
    for (int i = 0; i < K; i++) s += av[i] * wv[i];
    return s;
  endfunction

  function automatic logic [N-1:0] therm(input int c);
    logic [N-1:0] t = '0;
    for (int i = 0; i < N; i++) if (i < c) t[i] = 1'b1;
    return t;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply();
    @(negedge clk);
    for (int i = 0; i < K; i++) begin
      act_codes[2*i +: 2] = enc(av[i]);
      wgt_codes[2*i +: 2] = enc(wv[i]);
    end
    #1;
  endtask

  task automatic check_outputs(input string req);
    int cnt = dot() + N / 2;
    logic [N-1:0] es = therm(cnt);
    logic [OUT_LEN-1:0] ea;
    for (int j = 0; j < OUT_LEN; j++) ea[j] = (mtab[j] < cnt);
    chk(sorted_out == es, {req, " sorted"}, sorted_out, es);
    chk(act_out == ea, {req, " act"}, act_out, ea);
  endtask

  task automatic write_sel(input int a, input int idx);
    @(negedge clk);
    sel_we = 1'b1; sel_addr = AW'(a); sel_idx = IDX_W'(idx);
    @(negedge clk);
    sel_we = 1'b0;
    mtab[a] = idx;
  endtask

  task automatic set_all(input int a, input int w);
    for (int i = 0; i < K; i++) begin av[i] = a; wv[i] = w; end
  endtask

  // R6: reset table contents seen through the taps
  task automatic t_reset();
    for (int j = 0; j < OUT_LEN; j++) mtab[j] = (N * j) / OUT_LEN + N / (2 * OUT_LEN);
    set_all(0, 1); apply();
    chk(act_out == 4'b0011, "R6 reset taps at zero sum", act_out, 4'b0011);
    set_all(1, 1); apply();
    chk(act_out == 4'b0111, "R6 reset taps at max sum", act_out, 4'b0111);
    check_outputs("R6");
  endtask

  // R1: every code pair in lane 0, other lanes zero
  task automatic t_mult();
    for (int a = -1; a <= 1; a++)
      for (int w = -1; w <= 1; w++) begin
        set_all(0, 0); av[0] = a; wv[0] = w; apply();
        check_outputs("R1 multiplier");
      end
  endtask

  // R3 R4: extreme sums
  task automatic t_extremes();
    set_all(1, -1); apply();
    chk(sorted_out == 16'h0003, "R4 padding only", sorted_out, 16'h0003);
    set_all(1, 1); apply();
    chk(sorted_out == 16'h3fff, "R3 full sum", sorted_out, 16'h3fff);
    set_all(-1, -1); apply();
    check_outputs("R3 neg by neg");
  endtask

  // R7 R5: writes, hold, unordered table
  task automatic t_write();
    write_sel(0, 12); write_sel(1, 3); write_sel(2, 9); write_sel(3, 0);
    for (int n = 0; n <= K; n++) begin
      set_all(0, 1);
      for (int i = 0; i < n; i++) av[i] = 1;
      apply();
      check_outputs("R5 unordered table");
    end
    repeat (4) @(negedge clk);
    #1;
    check_outputs("R7 hold without write");
  endtask

  // R9: clipped ReLU with threshold b
  task automatic t_relu(input int b);
    for (int j = 0; j < OUT_LEN; j++) write_sel(j, N / 2 + b + j);
    for (int p = 0; p <= K; p++)
      for (int m = 0; m + p <= K; m += 2) begin
        int d, e;
        set_all(0, 1);
        for (int i = 0; i < p; i++) av[i] = 1;
        for (int i = p; i < p + m; i++) av[i] = -1;
        apply();
        d = dot();
        e = d - b;
        if (e < 0) e = 0;
        if (e > OUT_LEN) e = OUT_LEN;
        chk($countones(act_out) == e, "R9 clipped relu", $countones(act_out), e);
      end
  endtask

  // R2 R3 R5 R8: random vectors with ordered tables
  task automatic t_random();
    for (int r = 0; r < 20; r++) begin
      int t [OUT_LEN];
      for (int j = 0; j < OUT_LEN; j++) t[j] = $urandom_range(N - 1, 0);
      for (int x = 0; x < OUT_LEN; x++)
        for (int y = 0; y + 1 < OUT_LEN; y++)
          if (t[y] > t[y+1]) begin int tmp = t[y]; t[y] = t[y+1]; t[y+1] = tmp; end
      for (int j = 0; j < OUT_LEN; j++) write_sel(j, t[j]);
      for (int v = 0; v < 10; v++) begin
        for (int i = 0; i < K; i++) begin
          av[i] = $urandom_range(2, 0) - 1;
          wv[i] = $urandom_range(2, 0) - 1;
        end
        apply();
        check_outputs("R3 R5 random");
        chk(((sorted_out >> 1) & ~sorted_out) == 0, "R2 sorted thermometer", sorted_out, 0);
        chk(((act_out >> 1) & ~act_out) == 0, "R8 ordered table thermometer", act_out, 0);
      end
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sel_we = 1'b0; sel_addr = '0; sel_idx = '0;
    act_codes = {K{2'b01}}; wgt_codes = {K{2'b01}};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_mult();
    t_extremes();
    t_write();
    t_relu(0);
    t_relu(2);
    t_relu(-3);
    t_random();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule